// File: doc/BRIEF.md
# Supply-Fail Protection Sequencer

This block sits between the supply comparators and a battery-backed static memory and its host processor. Two digitized flags enter it: one says the supply has dropped below the write-protect trip level, and one says it has dropped further, below the backup switchover level. Either flag puts the system in a protected state. The memory is write-locked, its data outputs are forced to high impedance, and the processor reset line is pulled low.

When the supply returns, the block counts ticks of a slow timebase, nominally one per millisecond. It releases the memory lockout after a short window and releases the processor reset after a longer one. A new failure at any point in either window clears the count and puts every output back into the protected state.

A one-time arming latch keeps the backup energy source disconnected until the supply is seen valid for the first time. The latch is not touched by the ordinary reset or by any later supply loss. Only a dedicated factory clear disarms it. The reset output is an enable for an open-drain pull-down: 1 means the line is pulled low, and 0 means it is released to an external pull-up. Both windows are parameters counted in ticks, and `RST_TICKS` must be greater than `WP_TICKS`.

Top module: `pwrfail_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rst_pull_low`, `wr_protect` and `bus_isolate` are all 1 until a recovery sequence completes.
- R2: Each supply flag passes through a two-flop synchronizer. A 1 on `supply_low` or on `supply_dead` sets `rst_pull_low`, `wr_protect` and `bus_isolate` to 1 on the second rising clock edge after it is applied, and not earlier.
- R3: Once both synchronized flags are 0, `wr_protect` and `bus_isolate` fall to 0 on the edge that counts the `WP_TICKS`-th cycle with `tick_ms` high. Until then they stay 1.
- R4: `rst_pull_low` falls to 0 on the edge that counts the `RST_TICKS`-th tick after the supply becomes valid. It stays 0 however many further ticks arrive. `rst_pull_low` never falls while `wr_protect` is 1.
- R5: A supply flag raised during either recovery window sets all three protection outputs back to 1 and clears the tick count. The next recovery again needs the full `WP_TICKS` and `RST_TICKS`.
- R6: Ticks that arrive while a synchronized flag is 1 are not counted.
- R7: After `factory_clr`, `backup_en` is 0. It becomes 1 on the third rising edge after both flags are first 0. It then stays 1 through later supply failures and through pulses of `rst_n`.
- R8: A pulse on `factory_clr` (asynchronous, active high) clears `backup_en` to 0. It stays 0 while a supply flag is held at 1.
- R9: `bus_isolate` always equals `wr_protect`, and whenever `wr_protect` is 1, `rst_pull_low` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low logic reset; does not affect the arming latch |
| factory_clr | input | 1 | Asynchronous active-high clear of the backup arming latch |
| tick_ms | input | 1 | One-cycle timebase tick that counts the recovery windows |
| supply_low | input | 1 | Asynchronous flag: supply below write-protect trip level |
| supply_dead | input | 1 | Asynchronous flag: supply below backup switchover level |
| rst_pull_low | output | 1 | Open-drain reset enable; 1 pulls the processor reset low |
| wr_protect | output | 1 | Memory write lockout |
| bus_isolate | output | 1 | Forces the memory data outputs to high impedance |
| backup_en | output | 1 | Backup energy source enable, armed by the first valid supply |

## Verification
Recovery is driven one tick at a time, and the outputs are sampled one tick before each window boundary and on the boundary itself. This exposes an off-by-one error in either count and any swap of the two limits. Failures are injected in three situations: during normal running, inside the gap between the two windows, and with only the deeper flag raised. These cases show whether the synchronizer delay is exactly two edges, whether the count restarts from zero, and whether both flags reach the protection logic. Ticks are pulsed during a failure, and `rst_n` and `factory_clr` are pulsed separately. These cases tell counting apart from ignoring, and show which of the two resets disarms the backup source.

// File: rtl/pwrfail_supervisor.sv
module pwrfail_supervisor #(
  parameter int WP_TICKS  = 125,
  parameter int RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_clr,
  input  logic tick_ms,
  input  logic supply_low,
  input  logic supply_dead,
  output logic rst_pull_low,
  output logic wr_protect,
  output logic bus_isolate,
  output logic backup_en
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] WP_END  = CW'(WP_TICKS);
  localparam logic [CW-1:0] RST_END = CW'(RST_TICKS);

  logic [1:0]    low_sync, dead_sync;
  logic          fail_s;
  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_sync  <= 2'b11;
      dead_sync <= 2'b11;
    end else begin
      low_sync  <= {low_sync[0], supply_low};
      dead_sync <= {dead_sync[0], supply_dead};
    end
  end

  assign fail_s = low_sync[1] | dead_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (fail_s)                    cnt <= '0;
    else if (tick_ms && cnt != RST_END) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge factory_clr) begin
    if (factory_clr)  armed <= 1'b0;
    else if (!fail_s) armed <= 1'b1;
  end

  assign wr_protect   = fail_s | (cnt < WP_END);
  assign bus_isolate  = wr_protect;
  assign rst_pull_low = fail_s | (cnt < RST_END);
  assign backup_en    = armed;
endmodule

// File: rtl/pwrfail_supervisor_chk.sv
module pwrfail_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic factory_clr,
  input logic supply_low,
  input logic supply_dead,
  input logic rst_pull_low,
  input logic wr_protect,
  input logic bus_isolate,
  input logic backup_en
);
  // R9
  iso_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_isolate == wr_protect);

  // R9
  lock_implies_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> rst_pull_low);

  // R2
  fail_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(supply_low, 2) || $past(supply_dead, 2)) |-> (wr_protect && rst_pull_low));

  // R3
  lock_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_protect) |-> rst_pull_low);

  // R4
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull_low) |-> !wr_protect);

  // R7
  backup_sticky_chk: assert property (@(posedge clk) disable iff (factory_clr)
    backup_en |=> backup_en);
endmodule

bind pwrfail_supervisor pwrfail_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr),
  .supply_low(supply_low), .supply_dead(supply_dead),
  .rst_pull_low(rst_pull_low), .wr_protect(wr_protect),
  .bus_isolate(bus_isolate), .backup_en(backup_en)
);

// File: tb/pwrfail_supervisor_bench.sv
`timescale 1ns/1ps
module pwrfail_supervisor_bench;
  localparam int WP  = 5;
  localparam int RST = 9;

  logic clk = 1'b0;
  logic rst_n, factory_clr, tick_ms, supply_low, supply_dead;
  logic rst_pull_low, wr_protect, bus_isolate, backup_en;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwrfail_supervisor #(.WP_TICKS(WP), .RST_TICKS(RST)) u_pwrfail_supervisor (
    .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr), .tick_ms(tick_ms),
    .supply_low(supply_low), .supply_dead(supply_dead),
    .rst_pull_low(rst_pull_low), .wr_protect(wr_protect),
    .bus_isolate(bus_isolate), .backup_en(backup_en)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; @(negedge clk);
      tick_ms = 1'b0; @(negedge clk);
    end
  endtask

  task automatic check_prot(string req, logic exp);
    check(req, "rst_pull_low", rst_pull_low, exp);
    check(req, "wr_protect", wr_protect, exp);
    check(req, "bus_isolate", bus_isolate, exp);
  endtask

  task automatic release_supply();
    supply_low = 1'b0; supply_dead = 1'b0;
    cycles(3);
  endtask

  task automatic full_recovery(string req);
    ticks(WP - 1);
    check(req, "lock one tick early", wr_protect, 1'b1);
    ticks(1);
    check(req, "lock at window end", wr_protect, 1'b0);
    check(req, "isolate at window end", bus_isolate, 1'b0);
    check(req, "reset held after lock", rst_pull_low, 1'b1);
    ticks(RST - WP - 1);
    check(req, "reset one tick early", rst_pull_low, 1'b1);
    ticks(1);
    check(req, "reset at window end", rst_pull_low, 1'b0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; factory_clr = 1'b1; tick_ms = 1'b0;
    supply_low = 1'b1; supply_dead = 1'b1;
    cycles(2);
    check_prot("R1", 1'b1);
    factory_clr = 1'b0; cycles(1);
    rst_n = 1'b1; cycles(2);
    check_prot("R1", 1'b1);
    check("R7", "backup off before first valid", backup_en, 1'b0);
  endtask

  task automatic t_first_power_up();
    supply_low = 1'b0; supply_dead = 1'b0;
    cycles(2);
    check("R7", "backup before third edge", backup_en, 1'b0);
    cycles(1);
    check("R7", "backup armed", backup_en, 1'b1);
    check_prot("R1", 1'b1);
    // R3 R4
    full_recovery("R3/R4");
    ticks(4);
    check("R4", "reset stays released", rst_pull_low, 1'b0);
  endtask

  task automatic t_fail_latency();
    supply_low = 1'b1;
    cycles(1);
    check("R2", "lock after one edge", wr_protect, 1'b0);
    cycles(1);
    check_prot("R2", 1'b1);
    check("R7", "backup kept on fail", backup_en, 1'b1);
  endtask

  task automatic t_ticks_ignored_and_restart();
    ticks(WP + 2);
    check_prot("R6", 1'b1);
    release_supply();
    ticks(WP + 1);
    check("R5", "in reset-only window", rst_pull_low, 1'b1);
    supply_low = 1'b1; cycles(2);
    check_prot("R5", 1'b1);
    release_supply();
    full_recovery("R5");
  endtask

  task automatic t_deep_flag();
    supply_dead = 1'b1;
    cycles(2);
    check_prot("R2", 1'b1);
    release_supply();
    full_recovery("R2");
  endtask

  task automatic t_logic_reset_keeps_backup();
    rst_n = 1'b0; cycles(1);
    check_prot("R1", 1'b1);
    check("R7", "backup across rst_n", backup_en, 1'b1);
    rst_n = 1'b1; cycles(3);
    check("R1", "lock after rst_n", wr_protect, 1'b1);
    full_recovery("R1");
  endtask

  task automatic t_factory_clear();
    supply_low = 1'b1; cycles(2);
    factory_clr = 1'b1; cycles(1);
    factory_clr = 1'b0; cycles(3);
    check("R8", "backup cleared", backup_en, 1'b0);
    release_supply();
    check("R8", "backup rearmed", backup_en, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_first_power_up();
    t_fail_latency();
    t_ticks_ignored_and_restart();
    t_deep_flag();
    t_logic_reset_keeps_backup();
    t_factory_clear();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule